// File: doc/BRIEF.md
# Hardware Standby and Wake-up Sequencer

This block decides when the oscillator may run, when the chip's pads must float, and when the core is held in reset. It watches an active-low standby pin. While that pin is low, the block drops the oscillator enable, asks every pad to go high impedance and holds the core in reset. It does this at once, without waiting for a clock edge. No reset or wake request can override it. The block leaves standby only when the pin goes high again. The pin is first re-timed through a two-stage synchronizer. The block then runs a stabilization count while the internal reset stays asserted, and it lets the core out of reset only when the count has finished.

A 2-bit selection field sets the length of the stabilization count. The same count is used after a stop-mode wake request. In that case the core reset is not asserted, and a one-cycle done pulse marks the end of the wait. Only the power-on reset returns the selection field to `11`. The external reset pin and the software reset assert the core reset but leave the field unchanged. The field can be written only while the core is running.

Top module: `hsb_wake_seq`

## Requirements
- R1: When `standby_n` is low, `osc_en` is 0, `pins_hiz` is 1 and `core_rst` is 1 within the same clock period, before any clock edge. This holds whatever `ext_rst_n`, `sw_rst` and `stop_wake` are doing.
- R2: The block stays in standby for as long as `standby_n` is low. Pulses on `stop_wake`, `ext_rst_n` or `sw_rst` during standby do not release `osc_en`, `pins_hiz` or `core_rst`.
- R3: After `standby_n` rises, it passes through two synchronizer flops. The block then enters the reset wait: `osc_en` goes to 1 and `pins_hiz` goes to 0. `core_rst` falls exactly L+3 source clock edges after the rise, where L is the selected wait length.
- R4: The wait length L is 2^SHIFT0, 2^SHIFT1, 2^SHIFT2 or 2^SHIFT3 for `wait_sel` = 00, 01, 10 or 11. With the default parameters these are 2^10, 2^13, 2^15 and 2^17 source cycles.
- R5: `wait_sel` is set to 11 only while `por_n` is low. Pulses on `ext_rst_n` or `sw_rst` leave it unchanged.
- R6: A write (`sel_we` high at a clock edge) loads `sel_wdata` into `wait_sel` only when the block is running and `core_rst` is 0. A write during the reset wait or during an active external reset is ignored.
- R7: A `stop_wake` pulse while running starts a wait of length L. `core_rst` stays 0 throughout, and `stab_done` is first seen high L+1 edges after the request.
- R8: `stab_done` is a one-cycle pulse that follows only the last count of a wait. At the end of the reset wait it is high in the same cycle in which `core_rst` first reads 0.
- R9: `core_rst` is 1 while `ext_rst_n` is low or `sw_rst` is high, and returns to 0 as soon as either one is released, with no stabilization wait.
- R10: While `por_n` is low, the outputs take their standby values. After `por_n` rises with `standby_n` high, `core_rst` falls 2^SHIFT3+3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| sw_rst | input | 1 | Software reset request, active high |
| standby_n | input | 1 | Hardware standby pin, active low |
| stop_wake | input | 1 | Stop-mode wake request, one-cycle pulse |
| sel_we | input | 1 | Write strobe for the wait selection |
| sel_wdata | input | 2 | Wait selection value to write |
| osc_en | output | 1 | Oscillator enable |
| pins_hiz | output | 1 | Request for high impedance on all pads |
| core_rst | output | 1 | Internal reset to the core, active high |
| stab_done | output | 1 | One-cycle pulse at the end of a stabilization wait |
| wait_sel | output | 2 | Current wait selection |

## Verification
A vector table runs the wake paths for every selection code. Standby exits are tried with all four codes, and stop-mode wakes are tried with several codes. This separates the wait lengths from each other. It also separates the reset wait, which includes three extra cycles for synchronization and state entry, from the stop wait, which includes one. Directed patterns then drive standby together with an active reset, standby entered in the middle of a stop wait, and resets and wake pulses sent into standby. These show that standby has priority, that its entry is asynchronous and that it can only be left through the pin. External and software reset pulses, and writes during a wait, separate the power-on-only rule of the selection field from the rules of the other resets. A second instance with default parameters checks the full 2^17 power-on wait.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [1:0] {
    ST_STBY  = 2'd0,
    ST_RSTW  = 2'd1,
    ST_RUN   = 2'd2,
    ST_STOPW = 2'd3
  } hsb_state_e;

  // shift amount chosen by a 2-bit selection
  function automatic int unsigned hsb_pick_shift(
    input logic [1:0]  sel,
    input int unsigned s0,
    input int unsigned s1,
    input int unsigned s2,
    input int unsigned s3
  );
    case (sel)
      2'b00:   return s0;
      2'b01:   return s1;
      2'b10:   return s2;
      default: return s3;
    endcase
  endfunction

  // number of source cycles in a stabilization wait
  function automatic int unsigned hsb_wait_len(
    input logic [1:0]  sel,
    input int unsigned s0,
    input int unsigned s1,
    input int unsigned s2,
    input int unsigned s3
  );
    return 32'd1 << hsb_pick_shift(sel, s0, s1, s2, s3);
  endfunction

  function automatic int unsigned hsb_max4(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c,
    input int unsigned d
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m == 0) ? 1 : m;
  endfunction

endpackage

// File: rtl/hsb_pin_sync.sv
module hsb_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge clr_n) begin
          if (!clr_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge clr_n) begin
          if (!clr_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/hsb_sel_reg.sv
module hsb_sel_reg (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_ok,
  input  logic [1:0] wdata,
  output logic [1:0] sel
);

  // only the power-on reset touches this field
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     sel <= 2'b11;
    else if (wr_ok) sel <= wdata;
  end

endmodule

// File: rtl/hsb_stab_counter.sv
module hsb_stab_counter #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  assign hit = run && (cnt_q == last);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (run)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/hsb_seq_fsm.sv
module hsb_seq_fsm
  import hsb_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       sync_hi,
  input  logic       stop_wake,
  input  logic       wait_hit,
  output hsb_state_e state,
  output logic       cnt_clear,
  output logic       cnt_run,
  output logic       done
);

  hsb_state_e nxt;

  always_comb begin
    nxt = state;
    if (!sync_hi) begin
      nxt = ST_STBY;
    end else begin
      case (state)
        ST_STBY:  nxt = ST_RSTW;
        ST_RSTW:  if (wait_hit)  nxt = ST_RUN;
        ST_RUN:   if (stop_wake) nxt = ST_STOPW;
        ST_STOPW: if (wait_hit)  nxt = ST_RUN;
        default:  nxt = ST_STBY;
      endcase
    end
  end

  assign cnt_clear = (state == ST_STBY) || (state == ST_RUN);
  assign cnt_run   = sync_hi && ((state == ST_RSTW) || (state == ST_STOPW));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= ST_STBY;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= wait_hit && sync_hi;
    end
  end

endmodule

// File: rtl/hsb_wake_seq.sv
module hsb_wake_seq
  import hsb_pkg::*;
#(
  parameter int unsigned SHIFT0    = 10,
  parameter int unsigned SHIFT1    = 13,
  parameter int unsigned SHIFT2    = 15,
  parameter int unsigned SHIFT3    = 17,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic       clk_src,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       sw_rst,
  input  logic       standby_n,
  input  logic       stop_wake,
  input  logic       sel_we,
  input  logic [1:0] sel_wdata,
  output logic       osc_en,
  output logic       pins_hiz,
  output logic       core_rst,
  output logic       stab_done,
  output logic [1:0] wait_sel
);

  localparam int unsigned CNT_W = hsb_max4(SHIFT0, SHIFT1, SHIFT2, SHIFT3);

  // named internal events, used by the checker
  logic             sync_clr_n;
  logic             sync_hi;
  hsb_state_e       state;
  logic             in_standby;
  logic             in_rst_wait;
  logic             in_stop_wait;
  logic             in_run;
  logic             cnt_clear;
  logic             cnt_run;
  logic             wait_hit;
  logic             sel_wr_ok;
  logic [CNT_W-1:0] cnt_last;

  // low pin or power-on reset clears the synchronizer at once
  assign sync_clr_n = standby_n & por_n;

  hsb_pin_sync #(.STAGES(SYNC_STGS)) sync_i (
    .clk   (clk_src),
    .clr_n (sync_clr_n),
    .din   (1'b1),
    .dout  (sync_hi)
  );

  hsb_seq_fsm fsm_i (
    .clk       (clk_src),
    .por_n     (por_n),
    .sync_hi   (sync_hi),
    .stop_wake (stop_wake),
    .wait_hit  (wait_hit),
    .state     (state),
    .cnt_clear (cnt_clear),
    .cnt_run   (cnt_run),
    .done      (stab_done)
  );

  assign cnt_last = CNT_W'(hsb_wait_len(wait_sel, SHIFT0, SHIFT1, SHIFT2, SHIFT3) - 1);

  hsb_stab_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk   (clk_src),
    .por_n (por_n),
    .clear (cnt_clear),
    .run   (cnt_run),
    .last  (cnt_last),
    .hit   (wait_hit)
  );

  assign in_standby   = (state == ST_STBY);
  assign in_rst_wait  = (state == ST_RSTW);
  assign in_stop_wait = (state == ST_STOPW);
  assign in_run       = (state == ST_RUN);

  assign osc_en   = sync_hi && !in_standby;
  assign pins_hiz = !osc_en;
  assign core_rst = !sync_hi || in_standby || in_rst_wait || !ext_rst_n || sw_rst;

  assign sel_wr_ok = sel_we && sync_hi && (in_run || in_stop_wait) && !core_rst;

  hsb_sel_reg sel_i (
    .clk   (clk_src),
    .por_n (por_n),
    .wr_ok (sel_wr_ok),
    .wdata (sel_wdata),
    .sel   (wait_sel)
  );

endmodule

// File: rtl/hsb_wake_chk.sv
module hsb_wake_chk (
  input logic       clk_src,
  input logic       por_n,
  input logic       standby_n,
  input logic       ext_rst_n,
  input logic       sw_rst,
  input logic       osc_en,
  input logic       pins_hiz,
  input logic       core_rst,
  input logic       stab_done,
  input logic [1:0] wait_sel,
  input logic       sync_hi,
  input logic       in_standby,
  input logic       in_rst_wait,
  input logic       in_stop_wait,
  input logic       wait_hit,
  input logic       sel_wr_ok
);

  // R1
  standby_safe_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    !standby_n |-> (!osc_en && pins_hiz && core_rst));

  // R2
  standby_stays_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    (in_standby && !sync_hi) |=> in_standby);

  // R3
  rst_wait_holds_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    in_rst_wait |-> (core_rst && osc_en));

  // R5
  sel_stable_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    !sel_wr_ok |=> $stable(wait_sel));

  // R7
  stop_no_rst_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    (in_stop_wait && standby_n && ext_rst_n && !sw_rst) |-> !core_rst);

  // R8
  done_single_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    stab_done |=> !stab_done);

  // R8
  done_follows_hit_chk: assert property (@(posedge clk_src) disable iff (!por_n)
    stab_done |-> $past(wait_hit));

endmodule

bind hsb_wake_seq hsb_wake_chk chk_i (
  .clk_src      (clk_src),
  .por_n        (por_n),
  .standby_n    (standby_n),
  .ext_rst_n    (ext_rst_n),
  .sw_rst       (sw_rst),
  .osc_en       (osc_en),
  .pins_hiz     (pins_hiz),
  .core_rst     (core_rst),
  .stab_done    (stab_done),
  .wait_sel     (wait_sel),
  .sync_hi      (sync_hi),
  .in_standby   (in_standby),
  .in_rst_wait  (in_rst_wait),
  .in_stop_wait (in_stop_wait),
  .wait_hit     (wait_hit),
  .sel_wr_ok    (sel_wr_ok)
);

// File: tb/hsb_wake_seq_tb_top.sv
module hsb_wake_seq_tb_top;

  localparam int unsigned TS0 = 2;
  localparam int unsigned TS1 = 3;
  localparam int unsigned TS2 = 4;
  localparam int unsigned TS3 = 6;

  typedef struct packed {
    logic        use_stop;
    logic [1:0]  sel;
    logic [31:0] expect_n;
  } vec_t;

  // standby exit: 2^shift + 3 edges; stop wake: 2^shift + 1 edges
  localparam vec_t VEC [8] = '{
    '{1'b0, 2'b00, 32'd7},
    '{1'b0, 2'b01, 32'd11},
    '{1'b0, 2'b10, 32'd19},
    '{1'b0, 2'b11, 32'd67},
    '{1'b1, 2'b00, 32'd5},
    '{1'b1, 2'b01, 32'd9},
    '{1'b1, 2'b10, 32'd17},
    '{1'b1, 2'b11, 32'd65}
  };

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, sw_rst, standby_n, stop_wake, sel_we;
  logic [1:0] sel_wdata;
  logic       osc_en, pins_hiz, core_rst, stab_done;
  logic [1:0] wait_sel;

  logic       por_d_n;
  logic       osc_en_d, pins_hiz_d, core_rst_d, stab_done_d;
  logic [1:0] wait_sel_d;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int n;

  always #2 clk = ~clk;

  hsb_wake_seq #(.SHIFT0(TS0), .SHIFT1(TS1), .SHIFT2(TS2), .SHIFT3(TS3)) dut_i (
    .clk_src   (clk),
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .sw_rst    (sw_rst),
    .standby_n (standby_n),
    .stop_wake (stop_wake),
    .sel_we    (sel_we),
    .sel_wdata (sel_wdata),
    .osc_en    (osc_en),
    .pins_hiz  (pins_hiz),
    .core_rst  (core_rst),
    .stab_done (stab_done),
    .wait_sel  (wait_sel)
  );

  hsb_wake_seq dflt_i (
    .clk_src   (clk),
    .por_n     (por_d_n),
    .ext_rst_n (1'b1),
    .sw_rst    (1'b0),
    .standby_n (1'b1),
    .stop_wake (1'b0),
    .sel_we    (1'b0),
    .sel_wdata (2'b00),
    .osc_en    (osc_en_d),
    .pins_hiz  (pins_hiz_d),
    .core_rst  (core_rst_d),
    .stab_done (stab_done_d),
    .wait_sel  (wait_sel_d)
  );

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // which: 0 = wait for core_rst low, 1 = wait for stab_done high
  task automatic count_until(input int which, output int cnt);
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end while (((which == 0) ? core_rst : !stab_done) && cnt < 2000);
  endtask

  task automatic write_sel(input logic [1:0] v);
    sel_we = 1'b1;
    sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 195000);
        report();
      end
    end
  end

  initial begin
    por_n = 1'b0; por_d_n = 1'b1; ext_rst_n = 1'b1; sw_rst = 1'b0;
    standby_n = 1'b1; stop_wake = 1'b0; sel_we = 1'b0; sel_wdata = 2'b00;
    idle(3);

    // R10 reset state
    chk_eq("R10", "core_rst in por", core_rst, 1);
    chk_eq("R10", "pins_hiz in por", pins_hiz, 1);
    chk_eq("R10", "osc_en in por", osc_en, 0);
    chk_eq("R5", "wait_sel after por", wait_sel, 3);

    por_n = 1'b1;
    count_until(0, n);
    chk_eq("R10", "por release edges", n, (1 << TS3) + 3);
    chk_eq("R8", "done at release", stab_done, 1);
    @(negedge clk);
    chk_eq("R8", "done single pulse", stab_done, 0);

    // vector table: R3 R4 R7 R8
    foreach (VEC[i]) begin
      write_sel(VEC[i].sel);
      chk_eq("R6", "sel written", wait_sel, int'(VEC[i].sel));
      if (VEC[i].use_stop) begin
        stop_wake = 1'b1;
        count_until(1, n);
        stop_wake = 1'b0;
        chk_eq("R7", "stop wait edges", n, int'(VEC[i].expect_n));
        chk_eq("R7", "core_rst after stop", core_rst, 0);
      end else begin
        standby_n = 1'b0;
        idle(3);
        standby_n = 1'b1;
        count_until(0, n);
        chk_eq("R4", "standby exit edges", n, int'(VEC[i].expect_n));
        chk_eq("R8", "done with release", stab_done, 1);
      end
      idle(2);
    end

    // R5 / R9: other resets keep wait_sel
    write_sel(2'b01);
    ext_rst_n = 1'b0;
    idle(2);
    chk_eq("R9", "core_rst in ext reset", core_rst, 1);
    ext_rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R9", "core_rst after ext reset", core_rst, 0);
    chk_eq("R5", "sel after ext reset", wait_sel, 1);
    sw_rst = 1'b1;
    idle(2);
    chk_eq("R9", "core_rst in sw reset", core_rst, 1);
    sw_rst = 1'b0;
    @(negedge clk);
    chk_eq("R9", "core_rst after sw reset", core_rst, 0);
    chk_eq("R5", "sel after sw reset", wait_sel, 1);

    // R6: writes ignored during reset wait and during ext reset
    standby_n = 1'b0;
    idle(2);
    standby_n = 1'b1;
    idle(5);
    write_sel(2'b10);
    count_until(0, n);
    chk_eq("R6", "sel after write in wait", wait_sel, 1);
    ext_rst_n = 1'b0;
    write_sel(2'b11);
    ext_rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R6", "sel after write in ext reset", wait_sel, 1);

    // R2: nothing but the pin leaves standby
    standby_n = 1'b0;
    @(negedge clk);
    stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
    ext_rst_n = 1'b0; @(negedge clk); ext_rst_n = 1'b1;
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    idle(20);
    chk_eq("R2", "osc_en held off", osc_en, 0);
    chk_eq("R2", "pins_hiz held", pins_hiz, 1);
    chk_eq("R2", "core_rst held", core_rst, 1);
    standby_n = 1'b1;
    count_until(0, n);
    chk_eq("R3", "exit edges sel 01", n, (1 << TS1) + 3);

    // R1: entry with a reset active, asynchronous
    idle(2);
    ext_rst_n = 1'b0;
    standby_n = 1'b0;
    #1;
    chk_eq("R1", "hiz with reset", pins_hiz, 1);
    chk_eq("R1", "osc off with reset", osc_en, 0);
    @(negedge clk);
    standby_n = 1'b1;
    idle(5);
    chk_eq("R3", "osc_en in reset wait", osc_en, 1);
    chk_eq("R3", "pins_hiz in reset wait", pins_hiz, 0);
    ext_rst_n = 1'b1;
    count_until(0, n);

    // R7 / R1: standby entered in the middle of a stop wait
    idle(2);
    stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
    idle(3);
    chk_eq("R7", "core_rst in stop wait", core_rst, 0);
    chk_eq("R7", "osc_en in stop wait", osc_en, 1);
    standby_n = 1'b0;
    #1;
    chk_eq("R1", "osc off at once", osc_en, 0);
    chk_eq("R1", "core_rst at once", core_rst, 1);
    @(negedge clk);
    standby_n = 1'b1;
    count_until(0, n);
    chk_eq("R3", "exit after stop interrupt", n, (1 << TS1) + 3);

    // R4 / R10: default parameters, full power-on wait
    por_d_n = 1'b0;
    idle(2);
    chk_eq("R10", "default sel", wait_sel_d, 3);
    por_d_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (core_rst_d && n < 140000);
    chk_eq("R4", "default 2^17 wait", n, (1 << 17) + 3);

    report();
  end

endmodule